// File: doc/BRIEF.md
# Two-word immediate add pipeline

This block is a small in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. It runs a minimal instruction set of register add, register subtract, word load, no-op and a big-immediate add. The big-immediate add uses two consecutive instruction words. The first word names two source registers and a destination. The second word is a full 32-bit constant that follows the first word through the same stages, one cycle behind it.

The two-input ALU handles the big-immediate add in two passes. When the first word is in execute, the ALU sums the two source registers. One cycle later the constant word reaches execute, and the ALU adds that constant to the partial sum. The partial sum comes back from the memory stage over a bypass path, so no third adder input is needed and the register operands are not held anywhere.

The instruction array, data array and register file sit inside the block. They are loaded through plain write ports while reset is held. Every architectural instruction reports its destination and result on a retire strobe.

Top module: `bimm_pipe`

## Requirements
- R1: With `rst` high at a clock edge, the pipeline is cleared to no-ops and the fetch address is set to 0, so `ret_valid` stays low. After `rst` falls, the word at address 0 retires after the fourth rising edge. Each later instruction word takes one more edge, plus one edge for each interlock bubble.
- R2: Opcodes sit in bits 31:26, with no-op=0, add=1, subtract=2, load=3 and big-immediate add=4. Any other value acts as a no-op. Add retires rd(bits 15:11) = rs1(bits 25:21) + rs2(bits 20:16). Subtract retires rd = rs1 - rs2, all modulo 2^32.
- R3: A load writes the register named in bits 20:16 with the data word at index (rs1 + sign-extended bits 15:0) modulo the data depth.
- R4: Register 0 always reads as zero and is never written. An instruction that targets it still retires with `ret_rd`=0 and its computed value.
- R5: The big-immediate add retires rd = rs1 + rs2 + the following word. The following word is never decoded as an instruction, whatever its bits hold.
- R6: The retire strobe pulses exactly once for each add, subtract, load and big-immediate add, in program order. For the two-word instruction it pulses at the writeback of the constant word. It never pulses for no-ops or for the first word.
- R7: A result from the previous or second-previous add or subtract reaches the execute operands without a bubble. When both stages hold the same destination, the younger result wins.
- R8: An instruction that reads the destination (nonzero) of a load directly ahead of it waits one cycle in decode. If that instruction is a big-immediate add, its constant word waits in fetch during that same cycle. No other case inserts a bubble.
- R9: The source operands of a big-immediate add are forwarded like any other, including from an immediately preceding big-immediate add.
- R10: Writeback of the first word of a big-immediate add leaves the register file unchanged. Only the constant word's writeback writes the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction array write enable |
| imem_addr | input | log2(IMEM_DEPTH) | Instruction array write index |
| imem_wdata | input | 32 | Instruction word to store |
| dmem_we | input | 1 | Data array write enable |
| dmem_addr | input | log2(DMEM_DEPTH) | Data array write index |
| dmem_wdata | input | 32 | Data word to store |
| rf_we | input | 1 | Register file load enable |
| rf_addr | input | 5 | Register to load |
| rf_wdata | input | 32 | Register load value |
| ret_valid | output | 1 | One instruction retires this cycle |
| ret_rd | output | 5 | Destination of the retiring instruction |
| ret_data | output | 32 | Result of the retiring instruction |

## Verification
Any corrupted pipeline state shows up on the retire port, at most four cycles after the faulty stage, as a wrong value, wrong destination or wrong retire cycle. A missed or extra interlock bubble shifts every later retire by one cycle, so the bench compares the exact retire cycle as well as the data. A constant word that is decoded as an instruction, or a first word that retires, shows up as a retire the bench did not expect. A stale bypass selection shows up as a wrong sum in the very next retire.

// File: rtl/bimm_pkg.sv
package bimm_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int OPW  = 6;

    localparam logic [OPW-1:0] OPC_NOP   = 6'd0;
    localparam logic [OPW-1:0] OPC_ADD   = 6'd1;
    localparam logic [OPW-1:0] OPC_SUB   = 6'd2;
    localparam logic [OPW-1:0] OPC_LW    = 6'd3;
    localparam logic [OPW-1:0] OPC_ADDBI = 6'd4;

    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ADD    = 3'd1,
        K_SUB    = 3'd2,
        K_LW     = 3'd3,
        K_BIMAIN = 3'd4,
        K_BIIMM  = 3'd5
    } kind_e;

    // decode -> execute slot
    typedef struct packed {
        kind_e           kind;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [RIDX-1:0] rd;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
    } dec_t;

    // execute -> memory and memory -> writeback slots
    typedef struct packed {
        kind_e           kind;
        logic            wr;
        logic [RIDX-1:0] rd;
        logic [XLEN-1:0] res;
    } res_t;
endpackage

// File: rtl/bimm_wordmem.sv
module bimm_wordmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/bimm_regfile.sv
module bimm_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 pw_en,
    input  logic [$clog2(N)-1:0] pw_addr,
    input  logic [W-1:0]         pw_data,
    input  logic                 ld_en,
    input  logic [$clog2(N)-1:0] ld_addr,
    input  logic [W-1:0]         ld_data,
    input  logic [$clog2(N)-1:0] ra_addr,
    output logic [W-1:0]         ra_data,
    input  logic [$clog2(N)-1:0] rb_addr,
    output logic [W-1:0]         rb_data
);
    logic [W-1:0] regs_q [N];

    // pipeline writeback has priority over the load port
    always_ff @(posedge clk) begin
        if (pw_en && pw_addr != '0) regs_q[pw_addr] <= pw_data;
        else if (ld_en) regs_q[ld_addr] <= ld_data;
    end

    // write-through so decode sees a same-cycle writeback
    always_comb begin
        if (ra_addr == '0) ra_data = '0;
        else if (pw_en && pw_addr == ra_addr) ra_data = pw_data;
        else ra_data = regs_q[ra_addr];

        if (rb_addr == '0) rb_data = '0;
        else if (pw_en && pw_addr == rb_addr) rb_data = pw_data;
        else rb_data = regs_q[rb_addr];
    end
endmodule

// File: rtl/bimm_pipe.sv
module bimm_pipe
    import bimm_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    input  logic [XLEN-1:0]               imem_wdata,
    input  logic                          dmem_we,
    input  logic [$clog2(DMEM_DEPTH)-1:0] dmem_addr,
    input  logic [XLEN-1:0]               dmem_wdata,
    input  logic                          rf_we,
    input  logic [RIDX-1:0]               rf_addr,
    input  logic [XLEN-1:0]               rf_wdata,
    output logic                          ret_valid,
    output logic [RIDX-1:0]               ret_rd,
    output logic [XLEN-1:0]               ret_data
);
    localparam int IAW = $clog2(IMEM_DEPTH);
    localparam int DAW = $clog2(DMEM_DEPTH);

    typedef struct packed {
        logic [IAW-1:0]  pc;
        logic [XLEN-1:0] fd;        // fetch -> decode word
        logic            imm_pend;  // word in decode is a constant
        logic [RIDX-1:0] pend_rd;   // destination carried to the constant word
        dec_t            de;
        res_t            em;
        res_t            mw;
    } pipe_t;

    pipe_t           st_d, st_q;
    dec_t            dec_w;
    logic [OPW-1:0]  opc_w;
    logic            stall_w, rd_a_w, rd_b_w;
    logic [XLEN-1:0] rf_a_w, rf_b_w, ifetch_w, dload_w;
    logic [XLEN-1:0] op_a_w, op_b_w, alu_w;

    bimm_wordmem #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
        .raddr(st_q.pc), .rdata(ifetch_w)
    );

    bimm_wordmem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
        .clk(clk), .we(dmem_we), .waddr(dmem_addr), .wdata(dmem_wdata),
        .raddr(st_q.em.res[DAW-1:0]), .rdata(dload_w)
    );

    bimm_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk),
        .pw_en(st_q.mw.wr), .pw_addr(st_q.mw.rd), .pw_data(st_q.mw.res),
        .ld_en(rf_we), .ld_addr(rf_addr), .ld_data(rf_wdata),
        .ra_addr(st_q.fd[25:21]), .ra_data(rf_a_w),
        .rb_addr(st_q.fd[20:16]), .rb_data(rf_b_w)
    );

    // memory stage beats writeback; loads in memory have no value yet
    function automatic logic [XLEN-1:0] pick_operand(
        input logic [RIDX-1:0] src,
        input logic [XLEN-1:0] from_rf,
        input res_t            em,
        input res_t            mw
    );
        if (em.wr && em.kind != K_LW && em.rd == src) return em.res;
        if (mw.wr && mw.rd == src) return mw.res;
        return from_rf;
    endfunction

    always_comb begin
        // decode
        opc_w      = st_q.fd[31:26];
        dec_w      = '0;
        dec_w.kind = K_NOP;
        dec_w.rs1  = st_q.fd[25:21];
        dec_w.rs2  = st_q.fd[20:16];
        dec_w.rd   = st_q.fd[15:11];
        dec_w.a    = rf_a_w;
        dec_w.b    = rf_b_w;
        dec_w.imm  = {{(XLEN-16){st_q.fd[15]}}, st_q.fd[15:0]};
        if (st_q.imm_pend) begin
            dec_w.kind = K_BIIMM;
            dec_w.rd   = st_q.pend_rd;
            dec_w.imm  = st_q.fd;
        end else begin
            case (opc_w)
                OPC_ADD:   dec_w.kind = K_ADD;
                OPC_SUB:   dec_w.kind = K_SUB;
                OPC_LW: begin
                    dec_w.kind = K_LW;
                    dec_w.rd   = st_q.fd[20:16];
                end
                OPC_ADDBI: dec_w.kind = K_BIMAIN;
                default:   dec_w.kind = K_NOP;
            endcase
        end
        rd_a_w  = dec_w.kind inside {K_ADD, K_SUB, K_LW, K_BIMAIN};
        rd_b_w  = dec_w.kind inside {K_ADD, K_SUB, K_BIMAIN};
        stall_w = (st_q.de.kind == K_LW) && (st_q.de.rd != '0) &&
                  ((rd_a_w && dec_w.rs1 == st_q.de.rd) ||
                   (rd_b_w && dec_w.rs2 == st_q.de.rd));

        // execute
        op_a_w = pick_operand(st_q.de.rs1, st_q.de.a, st_q.em, st_q.mw);
        op_b_w = pick_operand(st_q.de.rs2, st_q.de.b, st_q.em, st_q.mw);
        if (st_q.de.kind == K_BIIMM) begin
            op_a_w = st_q.em.res;           // partial sum from memory stage
            op_b_w = st_q.de.imm;
        end else if (st_q.de.kind == K_LW) begin
            op_b_w = st_q.de.imm;
        end
        alu_w = (st_q.de.kind == K_SUB) ? (op_a_w - op_b_w) : (op_a_w + op_b_w);

        // next state
        st_d         = st_q;
        st_d.em.kind = st_q.de.kind;
        st_d.em.rd   = st_q.de.rd;
        st_d.em.res  = alu_w;
        st_d.em.wr   = (st_q.de.kind inside {K_ADD, K_SUB, K_LW, K_BIIMM}) &&
                       (st_q.de.rd != '0);

        st_d.mw = st_q.em;
        if (st_q.em.kind == K_LW) st_d.mw.res = dload_w;

        if (stall_w) begin
            st_d.de = '0;                   // bubble; fetch and decode hold
        end else begin
            st_d.pc       = st_q.pc + 1'b1;
            st_d.fd       = ifetch_w;
            st_d.de       = dec_w;
            st_d.imm_pend = (dec_w.kind == K_BIMAIN);
            if (dec_w.kind == K_BIMAIN) st_d.pend_rd = dec_w.rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ret_valid = st_q.mw.kind inside {K_ADD, K_SUB, K_LW, K_BIIMM};
    assign ret_rd    = st_q.mw.rd;
    assign ret_data  = st_q.mw.res;

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.pc == '0 && !ret_valid));

    // R8
    interlock_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        stall_w |=> (st_q.de.kind == K_NOP && $stable(st_q.pc) && $stable(st_q.fd)));

    // R5
    partial_in_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.de.kind == K_BIIMM) |-> (st_q.em.kind == K_BIMAIN));

    // R6
    retire_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mw.kind == K_BIIMM) |-> ($past(st_q.mw.kind) == K_BIMAIN));

    // R10
    main_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mw.kind == K_BIMAIN) |-> !st_q.mw.wr);

    // R4
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.mw.wr |-> (st_q.mw.rd != '0));
endmodule

// File: tb/tb_bimm_pipe.sv
module tb_bimm_pipe;
    localparam int ID = 64;
    localparam int DD = 64;
    localparam logic [5:0] O_NOP = 6'd0, O_ADD = 6'd1, O_SUB = 6'd2, O_LW = 6'd3, O_BI = 6'd4;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst = 1'b1;
    logic        imem_we = 1'b0, dmem_we = 1'b0, rf_we = 1'b0;
    logic [5:0]  imem_addr = '0, dmem_addr = '0;
    logic [4:0]  rf_addr = '0;
    logic [31:0] imem_wdata = '0, dmem_wdata = '0, rf_wdata = '0;
    logic        ret_valid;
    logic [4:0]  ret_rd;
    logic [31:0] ret_data;

    bimm_pipe #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) dut (
        .clk(clk), .rst(rst),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_data(ret_data)
    );

    typedef struct {
        int          cyc;
        logic [4:0]  rd;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] prog[$];
    string       tags[$];
    logic [31:0] init_r[32];
    logic [31:0] init_m[DD];
    int          total = 0, bad = 0, cyc = 0;
    bit          done = 1'b0;

    function automatic logic [31:0] enc_r(logic [5:0] op, int d, int a, int b);
        return {op, 5'(a), 5'(b), 5'(d), 11'd0};
    endfunction

    function automatic logic [31:0] enc_lw(int d, int a, int off);
        return {O_LW, 5'(a), 5'(d), 16'(off)};
    endfunction

    task automatic emit(logic [31:0] w, string t);
        prog.push_back(w);
        tags.push_back(t);
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected retires from the requirements: one slot per word, +1 per
    // load-use bubble; cycles counted in negedges from reset release
    task automatic build_expect();
        logic [31:0] mr[32];
        logic [31:0] w, a, b, v;
        int slot = 5, i = 0, prev_d = 0;
        bit prev_lw = 1'b0;
        for (int k = 0; k < 32; k++) mr[k] = (k == 0) ? 32'd0 : init_r[k];
        while (i < prog.size()) begin
            int s1, s2, d3;
            w  = prog[i];
            s1 = int'(w[25:21]);
            s2 = int'(w[20:16]);
            d3 = int'(w[15:11]);
            a  = (s1 == 0) ? 32'd0 : mr[s1];
            b  = (s2 == 0) ? 32'd0 : mr[s2];
            case (w[31:26])
                O_ADD, O_SUB: begin
                    if (prev_lw && prev_d != 0 && (prev_d == s1 || prev_d == s2)) slot++;
                    v = (w[31:26] == O_ADD) ? a + b : a - b;
                    expq.push_back('{slot, 5'(d3), v, tags[i]});
                    if (d3 != 0) mr[d3] = v;
                    slot++; i++; prev_lw = 1'b0;
                end
                O_LW: begin
                    if (prev_lw && prev_d != 0 && prev_d == s1) slot++;
                    v = init_m[(a + {{16{w[15]}}, w[15:0]}) & (DD - 1)];
                    expq.push_back('{slot, 5'(s2), v, tags[i]});
                    if (s2 != 0) mr[s2] = v;
                    prev_lw = 1'b1; prev_d = s2;
                    slot++; i++;
                end
                O_BI: begin
                    if (prev_lw && prev_d != 0 && (prev_d == s1 || prev_d == s2)) slot++;
                    v = a + b + prog[i+1];
                    expq.push_back('{slot + 1, 5'(d3), v, tags[i]});
                    if (d3 != 0) mr[d3] = v;
                    slot += 2; i += 2; prev_lw = 1'b0;
                end
                default: begin
                    slot++; i++; prev_lw = 1'b0;
                end
            endcase
        end
    endtask

    // driver: load under reset, push expectations, release, drain
    task automatic run_program();
        @(posedge clk); #2;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(ret_valid == 1'b0, "R1", "ret_valid in reset", ret_valid, 0);
        for (int i = 0; i < ID; i++) begin
            @(posedge clk); #2;
            imem_we = 1'b1; imem_addr = 6'(i);
            imem_wdata = (i < prog.size()) ? prog[i] : 32'd0;
        end
        @(posedge clk); #2;
        imem_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            rf_we = 1'b1; rf_addr = 5'(i); rf_wdata = init_r[i];
            @(posedge clk); #2;
        end
        rf_we = 1'b0;
        for (int i = 0; i < DD; i++) begin
            dmem_we = 1'b1; dmem_addr = 6'(i); dmem_wdata = init_m[i];
            @(posedge clk); #2;
        end
        dmem_we = 1'b0;
        check(ret_valid == 1'b0, "R1", "ret_valid held in reset", ret_valid, 0);
        build_expect();
        rst = 1'b0;
        repeat (45) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R6", "retires missing", expq.size(), 0);
        expq.delete();
        prog.delete();
        tags.delete();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t it;
        if (rst) begin
            cyc = 0;
        end else begin
            cyc = cyc + 1;
            if (ret_valid) begin
                if (expq.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R6 unexpected retire cyc=%0d rd=%0d data=%h expected none",
                             cyc, ret_rd, ret_data);
                end else begin
                    it = expq.pop_front();
                    total++;
                    if (cyc != it.cyc || ret_rd != it.rd || ret_data != it.val) begin
                        bad++;
                        $display("FAIL %s cyc/rd/data actual=%0d/%0d/%h expected=%0d/%0d/%h",
                                 it.tag, cyc, ret_rd, ret_data, it.cyc, it.rd, it.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) init_r[k] = (32'(k) * 32'h9E37_79B9) ^ 32'(k);
        for (int k = 0; k < DD; k++) init_m[k] = 32'hD000_0000 + 32'(k) * 32'h0001_0101;

        // R2 / R7: arithmetic and forwarding
        emit(enc_r(O_ADD, 3, 1, 2), "R1");
        emit(enc_r(O_SUB, 4, 3, 1), "R7");
        emit(enc_r(O_ADD, 5, 3, 4), "R7");
        emit(enc_r(O_SUB, 6, 2, 5), "R2");
        emit(enc_r(O_ADD, 7, 7, 7), "R2");
        emit(enc_r(O_ADD, 7, 7, 1), "R7");
        emit(enc_r(O_ADD, 8, 7, 0), "R7");
        emit(32'hFC00_0000, "R2");          // unknown opcode acts as no-op
        emit(enc_r(O_ADD, 9, 8, 6), "R2");
        run_program();

        // R3 / R8: loads and load-use bubbles
        emit(enc_lw(10, 0, 5), "R3");
        emit(enc_lw(11, 0, -3), "R3");
        emit(enc_r(O_ADD, 12, 11, 10), "R8");
        emit(enc_lw(13, 12, 0), "R3");
        emit(32'd0, "R8");
        emit(enc_r(O_ADD, 14, 13, 13), "R8");
        emit(enc_lw(15, 13, 2), "R3");
        emit(enc_lw(16, 15, 1), "R8");
        emit(enc_lw(17, 0, 7), "R3");
        emit(enc_r(O_SUB, 18, 1, 17), "R8");
        run_program();

        // R5 / R9 / R10: big-immediate add
        emit(enc_r(O_BI, 20, 1, 2), "R5");
        emit(32'h1234_5678, "R5");
        emit(enc_r(O_BI, 21, 20, 20), "R9");
        emit(enc_r(O_ADD, 22, 1, 2), "R5"); // constant that looks like an add
        emit(enc_r(O_ADD, 23, 21, 20), "R9");
        emit(enc_r(O_BI, 24, 23, 1), "R9");
        emit(32'hFFFF_FFFF, "R9");
        emit(enc_r(O_BI, 25, 25, 26), "R10");
        emit(32'h8000_0000, "R10");
        emit(32'd0, "R10");
        emit(enc_r(O_ADD, 27, 25, 0), "R10");
        emit(enc_r(O_SUB, 28, 25, 26), "R10");
        run_program();

        // R8: load followed by big-immediate add
        emit(enc_lw(28, 0, 9), "R8");
        emit(enc_r(O_BI, 29, 28, 1), "R8");
        emit(32'd100, "R8");
        emit(enc_lw(30, 0, 11), "R8");
        emit(enc_r(O_BI, 31, 2, 30), "R8");
        emit(32'd7, "R8");
        emit(enc_r(O_ADD, 1, 31, 29), "R9");
        run_program();

        // R4: register zero
        emit(enc_r(O_ADD, 0, 1, 2), "R4");
        emit(enc_r(O_ADD, 3, 0, 1), "R4");
        emit(enc_lw(0, 0, 4), "R4");
        emit(enc_r(O_ADD, 4, 0, 0), "R4");
        emit(enc_r(O_BI, 0, 1, 1), "R4");
        emit(32'd5, "R4");
        emit(enc_r(O_SUB, 5, 0, 2), "R4");
        run_program();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule